// File: doc/BRIEF.md
# NAND Flash Controller Register Bank

This block is the software-visible control and status bank of a NAND flash controller. A host reaches it through a plain 32-bit register bus: one access per cycle, qualified by a valid strobe, with a write flag, a byte address and write data. Read data is returned combinationally in the same cycle as the read strobe. The bank drives the controller's configuration fields, which are interface mode, timing word and chip-enable handling, to the datapath. It gathers event pulses from the datapath into a sticky interrupt status word and raises a single level-high interrupt line.

The interface configuration and timing registers are guarded by a key lock. The host first writes a 32-bit value whose low half is the key 0xA25E. Exactly one following write to either guarded register is then accepted, and the lock closes again. The interrupt status register clears on read. It never loses an event that arrives in the same cycle as the clearing read. A separate live status register mirrors the datapath's current state, delayed by one register stage, and is unaffected by reads.

Register map (byte offsets): 0x00 interface configuration, 0x04 timing, 0x08 key, 0x0C interrupt mask, 0x10 interrupt status, 0x14 live status, 0x18 chip-enable control. Any other address reads zero, and writes to it have no effect.

Top module: `nand_ctl_regbank`

## Requirements
- R1: After reset every register reads zero, all configuration outputs and irq are low, and the lock is closed.
- R2: A write of exactly 0x0000A25E to the key register (0x08) opens the lock. The first write to the configuration register (0x00) or the timing register (0x04) after that is accepted, and the lock then closes, so a second guarded write needs the key again.
- R3: A write to the configuration or timing register while the lock is closed leaves both the register and its outputs unchanged.
- R4: Configuration register bits drive the outputs: bit 0 cfg_bus16, bit 1 cfg_long_addr, bit 2 cfg_large_blk, bit 3 cfg_wp_en. Bits 31:4 read zero.
- R5: The timing register stores write bits 25:0, drives them unchanged on timing_cfg, and reads bits 31:26 as zero.
- R6: A key-register write of any value other than 0x0000A25E leaves the lock closed and also closes a lock that was open.
- R7: The interrupt mask register (0x0C) stores write bits 5:0 and reads bits 31:6 as zero.
- R8: An ev_pulse bit sets the matching status bit (0x10) one cycle later, and the bit stays set until the register is read. The layout is bit 0 write-protect fault, bit 1 ECC ready, bit 2 decode error, bit 3 decode failure, bit 4 controller ready, bit 5 NAND ready. Writes to the status register are ignored.
- R9: A read of the status register returns its current value and clears all its bits at the end of that cycle.
- R10: An event pulse in the same cycle as a status read is held in the status register after the clear.
- R11: irq is high exactly when some status bit and its mask bit are both set. A mask write can raise irq for status bits that are already latched.
- R12: The live status register (0x14) reads the status inputs one cycle after they are applied: bit 0 NAND ready, bit 1 controller ready, bit 2 ECC ready, bit 3 errors detected, bits 5:4 corrected-error count minus one, bit 6 decoder failure. Reads do not clear it, and writes to it are ignored.
- R13: Chip-enable control register (0x18) bit 0 drives ce_auto. Other bits are ignored and read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (8) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the read cycle, zero otherwise |
| ev_pulse | input | 6 | Datapath event pulses, in the status bit layout |
| st_nand_rdy | input | 1 | Live NAND ready |
| st_ctl_rdy | input | 1 | Live controller ready |
| st_ecc_rdy | input | 1 | Live ECC ready |
| st_err_det | input | 1 | Live errors detected |
| st_err_cnt | input | 2 | Corrected-error count minus one |
| st_dec_fail | input | 1 | Live decoder failure |
| cfg_bus16 | output | 1 | 16-bit bus mode |
| cfg_long_addr | output | 1 | Five-byte addressing |
| cfg_large_blk | output | 1 | Large-block device |
| cfg_wp_en | output | 1 | Write-protect enable |
| timing_cfg | output | TIM_W (26) | Timing word |
| ce_auto | output | 1 | Controller drives chip enable automatically |
| irq | output | 1 | Level-high interrupt |

## Verification
A status read and a new event pulse can fall in the same cycle, and the clear must not swallow the event. The bench provokes this by latching one event, then issuing the status read while a pulse of a different bit is on ev_pulse. The read must return only the old bit, and the next read must return only the new one. A second collision, a guarded write arriving right after the lock closes, is judged by reading the register back unchanged.

// File: rtl/nand_rb_pkg.sv
package nand_rb_pkg;

    localparam int unsigned DATA_W  = 32;
    localparam int unsigned IRQ_W   = 6;
    localparam int unsigned LIVE_W  = 7;
    localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0000_A25E;

    // word index of each register; byte offset = index * 4
    typedef enum logic [2:0] {
        RB_CFG  = 3'd0,
        RB_TIM  = 3'd1,
        RB_KEY  = 3'd2,
        RB_MASK = 3'd3,
        RB_STAT = 3'd4,
        RB_LIVE = 3'd5,
        RB_CE   = 3'd6
    } rb_sel_e;

    typedef struct packed {
        logic wp_en;
        logic large_blk;
        logic long_addr;
        logic bus16;
    } if_cfg_t;

    typedef struct packed {
        logic       dec_fail;
        logic [1:0] err_cnt;
        logic       err_det;
        logic       ecc_rdy;
        logic       ctl_rdy;
        logic       nand_rdy;
    } live_t;

    function automatic logic rb_hit(input logic [DATA_W-1:0] byte_addr,
                                    input rb_sel_e sel);
        return byte_addr == {27'b0, sel, 2'b00};
    endfunction

endpackage

// File: rtl/rb_key_lock.sv
module rb_key_lock
    import nand_rb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              key_we,
    input  logic [DATA_W-1:0] key_val,
    input  logic              guarded_we,
    output logic              open_q
);
    always_ff @(posedge clk) begin
        if (rst)
            open_q <= 1'b0;
        else if (key_we)
            open_q <= (key_val == UNLOCK_WORD);
        else if (guarded_we)
            open_q <= 1'b0;
    end
endmodule

// File: rtl/rb_irq_latch.sv
module rb_irq_latch #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] ev,
    input  logic         rd_clr,
    input  logic         mask_we,
    input  logic [N-1:0] mask_d,
    output logic [N-1:0] stat_q,
    output logic [N-1:0] mask_q,
    output logic         irq
);
    logic [N-1:0] stat_keep;

    assign stat_keep = rd_clr ? '0 : stat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= '0;
        end else begin
            stat_q <= stat_keep | ev;
            if (mask_we)
                mask_q <= mask_d;
        end
    end

    assign irq = |(stat_q & mask_q);
endmodule

// File: rtl/rb_live_sync.sv
module rb_live_sync #(
    parameter int unsigned W = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/nand_ctl_regbank.sv
module nand_ctl_regbank
    import nand_rb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned TIM_W  = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [5:0]        ev_pulse,
    input  logic              st_nand_rdy,
    input  logic              st_ctl_rdy,
    input  logic              st_ecc_rdy,
    input  logic              st_err_det,
    input  logic [1:0]        st_err_cnt,
    input  logic              st_dec_fail,
    output logic              cfg_bus16,
    output logic              cfg_long_addr,
    output logic              cfg_large_blk,
    output logic              cfg_wp_en,
    output logic [TIM_W-1:0]  timing_cfg,
    output logic              ce_auto,
    output logic              irq
);
    localparam int unsigned CFG_W = $bits(if_cfg_t);

    logic [DATA_W-1:0] addr_w;
    logic wr, rd;
    logic hit_cfg, hit_tim, hit_key, hit_mask, hit_stat, hit_live, hit_ce;
    logic guarded_we, lock_open, accept_we;
    if_cfg_t cfg_q;
    logic [TIM_W-1:0] tim_q;
    logic ce_q;
    logic [IRQ_W-1:0] irq_stat, irq_mask;
    live_t live_d, live_q;
    logic [DATA_W-1:0] rd_mux;

    assign addr_w   = DATA_W'(bus_addr);
    assign wr       = bus_valid & bus_write;
    assign rd       = bus_valid & ~bus_write;
    assign hit_cfg  = rb_hit(addr_w, RB_CFG);
    assign hit_tim  = rb_hit(addr_w, RB_TIM);
    assign hit_key  = rb_hit(addr_w, RB_KEY);
    assign hit_mask = rb_hit(addr_w, RB_MASK);
    assign hit_stat = rb_hit(addr_w, RB_STAT);
    assign hit_live = rb_hit(addr_w, RB_LIVE);
    assign hit_ce   = rb_hit(addr_w, RB_CE);

    assign guarded_we = wr & (hit_cfg | hit_tim);
    assign accept_we  = guarded_we & lock_open;

    rb_key_lock u_lock (
        .clk        (clk),
        .rst        (rst),
        .key_we     (wr & hit_key),
        .key_val    (bus_wdata),
        .guarded_we (guarded_we),
        .open_q     (lock_open)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tim_q <= '0;
            ce_q  <= 1'b0;
        end else begin
            if (accept_we && hit_cfg) cfg_q <= if_cfg_t'(bus_wdata[CFG_W-1:0]);
            if (accept_we && hit_tim) tim_q <= bus_wdata[TIM_W-1:0];
            if (wr && hit_ce)         ce_q  <= bus_wdata[0];
        end
    end

    rb_irq_latch #(.N(IRQ_W)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev_pulse),
        .rd_clr  (rd & hit_stat),
        .mask_we (wr & hit_mask),
        .mask_d  (bus_wdata[IRQ_W-1:0]),
        .stat_q  (irq_stat),
        .mask_q  (irq_mask),
        .irq     (irq)
    );

    assign live_d = '{dec_fail: st_dec_fail, err_cnt: st_err_cnt, err_det: st_err_det,
                      ecc_rdy: st_ecc_rdy, ctl_rdy: st_ctl_rdy, nand_rdy: st_nand_rdy};

    rb_live_sync #(.W(LIVE_W)) u_live (
        .clk (clk),
        .rst (rst),
        .d   (live_d),
        .q   (live_q)
    );

    always_comb begin
        rd_mux = '0;
        if (hit_cfg)  rd_mux = DATA_W'(cfg_q);
        if (hit_tim)  rd_mux = DATA_W'(tim_q);
        if (hit_mask) rd_mux = DATA_W'(irq_mask);
        if (hit_stat) rd_mux = DATA_W'(irq_stat);
        if (hit_live) rd_mux = DATA_W'(live_q);
        if (hit_ce)   rd_mux = DATA_W'(ce_q);
        bus_rdata = rd ? rd_mux : '0;
    end

    assign cfg_bus16     = cfg_q.bus16;
    assign cfg_long_addr = cfg_q.long_addr;
    assign cfg_large_blk = cfg_q.large_blk;
    assign cfg_wp_en     = cfg_q.wp_en;
    assign timing_cfg    = tim_q;
    assign ce_auto       = ce_q;
endmodule

// File: rtl/nand_ctl_regbank_chk.sv
module nand_ctl_regbank_chk
    import nand_rb_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned TIM_W  = 26
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [5:0]        ev_pulse,
    input logic [3:0]        cfg_vec,
    input logic [TIM_W-1:0]  timing_cfg,
    input logic              irq,
    input logic              lock_open,
    input logic [5:0]        irq_stat,
    input logic [5:0]        irq_mask
);
    logic [31:0] a32;
    logic guarded_wr, stat_rd, mask_wr;

    assign a32        = 32'(bus_addr);
    assign guarded_wr = bus_valid && bus_write && (rb_hit(a32, RB_CFG) || rb_hit(a32, RB_TIM));
    assign stat_rd    = bus_valid && !bus_write && rb_hit(a32, RB_STAT);
    assign mask_wr    = bus_valid && bus_write && rb_hit(a32, RB_MASK);

    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (cfg_vec == 4'b0 && timing_cfg == '0 && !irq && !lock_open));

    p_relock_after_write_r2: assert property (@(posedge clk) disable iff (rst)
        (guarded_wr && lock_open) |=> !lock_open);

    p_locked_write_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        (guarded_wr && !lock_open) |=> ($stable(cfg_vec) && $stable(timing_cfg)));

    p_clear_on_read_r9: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && ev_pulse == 6'b0) |=> (irq_stat == 6'b0));

    p_event_kept_r10: assert property (@(posedge clk) disable iff (rst)
        stat_rd |=> ((irq_stat & $past(ev_pulse)) == $past(ev_pulse)));

    p_irq_raised_r11: assert property (@(posedge clk) disable iff (rst)
        ((|(ev_pulse & irq_mask)) && !mask_wr) |=> irq);
endmodule

bind nand_ctl_regbank nand_ctl_regbank_chk #(.ADDR_W(ADDR_W), .TIM_W(TIM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_valid  (bus_valid),
    .bus_write  (bus_write),
    .bus_addr   (bus_addr),
    .ev_pulse   (ev_pulse),
    .cfg_vec    ({cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16}),
    .timing_cfg (timing_cfg),
    .irq        (irq),
    .lock_open  (lock_open),
    .irq_stat   (irq_stat),
    .irq_mask   (irq_mask)
);

// File: tb/test_nand_ctl_regbank.sv
`timescale 1ns/1ps
module test_nand_ctl_regbank;
    localparam int ADDR_W = 8;
    localparam int TIM_W  = 26;
    localparam logic [7:0] A_CFG = 8'h00, A_TIM = 8'h04, A_KEY = 8'h08, A_MASK = 8'h0C,
                           A_STAT = 8'h10, A_LIVE = 8'h14, A_CE = 8'h18;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bus_valid = 1'b0, bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [5:0] ev_pulse = '0;
    logic st_nand_rdy = 0, st_ctl_rdy = 0, st_ecc_rdy = 0, st_err_det = 0, st_dec_fail = 0;
    logic [1:0] st_err_cnt = '0;
    logic cfg_bus16, cfg_long_addr, cfg_large_blk, cfg_wp_en, ce_auto, irq;
    logic [TIM_W-1:0] timing_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    nand_ctl_regbank #(.ADDR_W(ADDR_W), .TIM_W(TIM_W)) i_nand_ctl_regbank (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_pulse(ev_pulse), .st_nand_rdy(st_nand_rdy), .st_ctl_rdy(st_ctl_rdy),
        .st_ecc_rdy(st_ecc_rdy), .st_err_det(st_err_det), .st_err_cnt(st_err_cnt),
        .st_dec_fail(st_dec_fail), .cfg_bus16(cfg_bus16), .cfg_long_addr(cfg_long_addr),
        .cfg_large_blk(cfg_large_blk), .cfg_wp_en(cfg_wp_en), .timing_cfg(timing_cfg),
        .ce_auto(ce_auto), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 0; bus_write = 0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic pulse(input logic [5:0] v);
        @(negedge clk);
        ev_pulse = v;
        @(negedge clk);
        ev_pulse = '0;
    endtask

    function automatic logic [31:0] cfg_pins();
        return {28'b0, cfg_wp_en, cfg_large_blk, cfg_long_addr, cfg_bus16};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        rd(A_CFG, d);  chk("R1 cfg", d, 0);
        rd(A_TIM, d);  chk("R1 timing", d, 0);
        rd(A_MASK, d); chk("R1 mask", d, 0);
        rd(A_STAT, d); chk("R1 status", d, 0);
        rd(A_LIVE, d); chk("R1 live", d, 0);
        rd(A_CE, d);   chk("R1 ce", d, 0);
        chk("R1 outputs", {cfg_pins(), ce_auto, irq}, 0);
        chk("R1 timing pins", 32'(timing_cfg), 0);
    endtask

    task automatic t_locked();
        logic [31:0] d;
        wr(A_CFG, 32'hF);
        wr(A_TIM, 32'h155);
        rd(A_CFG, d); chk("R3 cfg locked", d, 0);
        rd(A_TIM, d); chk("R3 timing locked", d, 0);
        chk("R3 cfg pins", cfg_pins(), 0);
        chk("R3 timing pins", 32'(timing_cfg), 0);
    endtask

    task automatic t_unlock();
        logic [31:0] d;
        wr(A_KEY, 32'h0000_A25E);
        wr(A_CFG, 32'h6);
        rd(A_CFG, d); chk("R2 accepted", d, 32'h6);
        chk("R4 long+large pins", cfg_pins(), 32'h6);
        wr(A_CFG, 32'hF);
        rd(A_CFG, d); chk("R2 relocked", d, 32'h6);
        wr(A_KEY, 32'h0000_A25E);
        wr(A_TIM, 32'hFFFF_FFFF);
        rd(A_TIM, d); chk("R5 timing read", d, 32'h03FF_FFFF);
        chk("R5 timing pins", 32'(timing_cfg), 32'h03FF_FFFF);
        wr(A_TIM, 32'h0);
        rd(A_TIM, d); chk("R2 timing relocked", d, 32'h03FF_FFFF);
        wr(A_KEY, 32'h0000_A25E);
        wr(A_CFG, 32'hFFFF_FFF9);
        rd(A_CFG, d); chk("R4 cfg read", d, 32'h9);
        chk("R4 bus16+wp pins", cfg_pins(), 32'h9);
    endtask

    task automatic t_wrong_key();
        logic [31:0] d;
        wr(A_KEY, 32'h0000_1234);
        wr(A_CFG, 32'h0);
        rd(A_CFG, d); chk("R6 bad key", d, 32'h9);
        wr(A_KEY, 32'h0001_A25E);
        wr(A_CFG, 32'h0);
        rd(A_CFG, d); chk("R6 upper bits in key", d, 32'h9);
        wr(A_KEY, 32'h0000_A25E);
        wr(A_KEY, 32'h0000_0000);
        wr(A_CFG, 32'h0);
        rd(A_CFG, d); chk("R6 bad key closes", d, 32'h9);
    endtask

    task automatic t_events();
        logic [31:0] d;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, d); chk("R7 mask width", d, 32'h3F);
        wr(A_MASK, 32'h0);
        pulse(6'h04);
        chk("R11 masked off", 32'(irq), 0);
        rd(A_STAT, d); chk("R8 decode error bit", d, 32'h04);
        rd(A_STAT, d); chk("R9 cleared", d, 0);
        pulse(6'h01);
        pulse(6'h20);
        wr(A_STAT, 32'h0);
        rd(A_STAT, d); chk("R8 sticky, write ignored", d, 32'h21);
        rd(A_STAT, d); chk("R9 cleared again", d, 0);
    endtask

    task automatic t_irq();
        logic [31:0] d;
        wr(A_MASK, 32'h10);
        pulse(6'h10);
        chk("R11 irq raised", 32'(irq), 1);
        rd(A_STAT, d);
        chk("R11 irq after clear", 32'(irq), 0);
        pulse(6'h02);
        chk("R11 unmasked bit only", 32'(irq), 0);
        wr(A_MASK, 32'h02);
        chk("R11 mask raises irq", 32'(irq), 1);
        rd(A_STAT, d); chk("R9 ecc ready read", d, 32'h02);
        chk("R11 irq low", 32'(irq), 0);
    endtask

    task automatic t_collide();
        logic [31:0] d;
        pulse(6'h01);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = A_STAT; ev_pulse = 6'h20;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_valid = 0; ev_pulse = '0;
        chk("R10 read returns old", d, 32'h01);
        rd(A_STAT, d); chk("R10 event kept", d, 32'h20);
    endtask

    task automatic t_live();
        logic [31:0] d;
        @(negedge clk);
        st_nand_rdy = 1; st_err_cnt = 2'd2; st_dec_fail = 1;
        rd(A_LIVE, d); chk("R12 live bits", d, 32'h61);
        rd(A_LIVE, d); chk("R12 not cleared", d, 32'h61);
        wr(A_LIVE, 32'h0);
        @(negedge clk);
        st_nand_rdy = 0; st_err_cnt = 0; st_dec_fail = 0;
        st_ctl_rdy = 1; st_ecc_rdy = 1; st_err_det = 1;
        rd(A_LIVE, d); chk("R12 other bits", d, 32'h0E);
    endtask

    task automatic t_ce();
        logic [31:0] d;
        wr(A_CE, 32'h1);
        chk("R13 ce_auto on", 32'(ce_auto), 1);
        rd(A_CE, d); chk("R13 read", d, 32'h1);
        wr(A_CE, 32'hFFFF_FFFE);
        chk("R13 ce_auto off", 32'(ce_auto), 0);
        rd(A_CE, d); chk("R13 upper ignored", d, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_locked();
        t_unlock();
        t_wrong_key();
        t_events();
        t_irq();
        t_collide();
        t_live();
        t_ce();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule